// File: doc/BRIEF.md
# Configurable Logic Macrocell

This block is one macrocell of a programmable logic fabric. It receives a single sum-of-products term from the array and can invert it through a polarity XOR. The resulting data bit goes to two outputs. One output feeds back into the local array and the other drives the routing. Each output can take the data bit directly (combinational path) or take the value of the cell's storage element. The storage element can run as an edge-triggered D register, a flow-through D latch or a toggle flip-flop.

The cell clock, clock enable, reset and preset each come from a selector with its own polarity bit. The clock can be taken from global, local or product-term lines. The enable can be taken from global, local or product-term lines. Reset and preset can each be taken from global lines or from their own product-term line.

All configuration is static input. Cell clocks are data lines sampled by the system clock `clk`. An active cell-clock edge is a 0-to-1 change of the polarity-adjusted selected line between two consecutive `clk` samples. A selected reset or preset forces the stored value at once, without waiting for a cell-clock edge.

Top module: `mc_macrocell`

## Requirements
- R1: The data bit is `sop ^ cfg_xor_inv`. An output set to the combinational path shows this bit in the same cycle.
- R2: `cfg_fb_store` and `cfg_rt_store` choose, independently, the path for `fb_out` and for `rt_out`: 0 selects the data bit and 1 selects the storage value.
- R3: With `cfg_mode` at 2'b00 (D register), the state takes the data bit on an active cell-clock edge while the enable is high. The new value is visible after the next `clk` rising edge. At all other times the state holds.
- R4: With `cfg_mode` at 2'b01 (latch), the storage value follows the data bit in the same cycle while the selected clock level and the enable are both high. When either is low, the storage value keeps the last value it passed.
- R5: With `cfg_mode` at 2'b10 (toggle), the state inverts on an active edge when the enable is high and the data bit is 1. With `cfg_mode` at 2'b11, the cell behaves exactly as a D register.
- R6: The clock selector maps its index as follows: index 0 is a constant 0, indices 1 to 4 are `gclk[0..3]`, indices 5 to 7 are `lclk[0..2]`, and index 8 is `pt_clk`. The selected line is XORed with `cfg_ck_inv`, so with `cfg_ck_inv` set the falling edge of the line is the active edge. Lines that are not selected have no effect.
- R7: The enable selector maps its index as follows: index 0 is a constant 0, indices 1 to 2 are `gce`, indices 3 to 4 are `lce`, and index 5 is `pt_ce`. The selected line is XORed with `cfg_ce_inv`, so index 0 with the inversion set means the cell is always enabled.
- R8: The reset and preset selectors each map index 0 to a constant 0, indices 1 to 2 to `gsr[0..1]` and index 3 to their own product-term line (`pt_rst` or `pt_pre`). Each has its own inversion bit. An active reset forces the storage value to 0 and an active preset forces it to 1, in the same cycle, regardless of the cell clock.
- R9: When reset and preset are both active, the storage value is 0.
- R10: A low `rst_n` at a `clk` rising edge clears the state to 0.
- R11: A clock or enable index beyond the last source selects a constant 0 before the polarity bit is applied.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that samples all cell-clock lines |
| rst_n | input | 1 | Synchronous active-low system reset |
| cfg_mode | input | 2 | Storage mode: 00 D register, 01 latch, 10 toggle, 11 D register |
| cfg_xor_inv | input | 1 | Inverts the product-term input |
| cfg_fb_store | input | 1 | Feedback output path: 1 storage, 0 combinational |
| cfg_rt_store | input | 1 | Routing output path: 1 storage, 0 combinational |
| cfg_ck_sel | input | 4 | Clock source index |
| cfg_ck_inv | input | 1 | Clock polarity |
| cfg_ce_sel | input | 3 | Enable source index |
| cfg_ce_inv | input | 1 | Enable polarity |
| cfg_rs_sel | input | 2 | Reset source index |
| cfg_rs_inv | input | 1 | Reset polarity |
| cfg_ps_sel | input | 2 | Preset source index |
| cfg_ps_inv | input | 1 | Preset polarity |
| gclk | input | 4 | Global clock lines |
| lclk | input | 3 | Local clock lines |
| pt_clk | input | 1 | Product-term clock |
| gce | input | 2 | Global enable lines |
| lce | input | 2 | Local enable lines |
| pt_ce | input | 1 | Product-term enable |
| gsr | input | 2 | Global set/reset lines |
| pt_rst | input | 1 | Product-term reset |
| pt_pre | input | 1 | Product-term preset |
| sop | input | 1 | Sum-of-products input from the array |
| fb_out | output | 1 | Feedback output to the local array |
| rt_out | output | 1 | Output to the routing |

## Verification
The bench drives a cell clock through inverted polarity. A design that treated every change as an edge, or that ignored the inversion, would capture on the wrong transition. Toggle mode is run with a data bit of 0, and mode 2'b11 is run with data 1 on a stored 1. A cell that toggled unconditionally would differ from the expected values here, and so would one that treated 2'b11 as toggle.

The latch is checked in the same cycle it opens and while the enable closes it. A latch that registered its input, or ignored the enable, would lag or leak. Reset and preset are raised together and also against an active clock edge. A design that let preset or the clock win would show 1. An out-of-range clock index is driven with every clock line toggling, to catch a decoder that wraps the index.

// File: rtl/mc_pkg.sv
// Package: shared types for the macrocell.
// Assumes: storage mode encodings are fixed by the configuration format.
package mc_pkg;

    typedef enum logic [1:0] {
        MODE_DREG   = 2'b00,
        MODE_LATCH  = 2'b01,
        MODE_TOGGLE = 2'b10,
        MODE_DALT   = 2'b11
    } mc_mode_e;

endpackage

// File: rtl/mc_src_sel.sv
// Module: picks one control line out of a source vector by index and
// applies a polarity bit. Any index past the last source reads as 0.
// Assumes: src[0] is tied to 0 by the parent.
module mc_src_sel #(
    parameter int N_SRC = 4,
    parameter int SEL_W = (N_SRC > 1) ? $clog2(N_SRC) : 1
) (
    input  logic [N_SRC-1:0] src,
    input  logic [SEL_W-1:0] sel,
    input  logic             inv,
    output logic             sig
);

    logic picked;

    // Decode the index into one source line, 0 when out of range.
    always_comb begin
        picked = 1'b0;
        for (int i = 0; i < N_SRC; i++) begin
            if (sel == SEL_W'(i)) picked = src[i];
        end
    end

    // Apply the per-cell polarity.
    assign sig = picked ^ inv;

endmodule

// File: rtl/mc_edge.sv
// Module: detects a 0-to-1 change of a cell-clock level between two
// consecutive system-clock samples.
// Assumes: the level is stable around each rising edge of clk.
module mc_edge (
    input  logic clk,
    input  logic rst_n,
    input  logic lvl,
    output logic rise
);

    logic lvl_q;

    // Track the previous level; also tracked in reset so no false edge appears.
    always_ff @(posedge clk) begin
        if (!rst_n) lvl_q <= lvl;
        else        lvl_q <= lvl;
    end

    // Report a rise when the level went from 0 to 1.
    assign rise = lvl & ~lvl_q;

endmodule

// File: rtl/mc_store.sv
// Module: storage element of the macrocell (D register, flow-through
// latch or toggle) with overriding reset and preset.
// Assumes: reset/preset/clock/enable are already polarity-adjusted.
module mc_store
    import mc_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  mc_mode_e mode,
    input  logic     d,
    input  logic     ck_lvl,
    input  logic     ck_rise,
    input  logic     en,
    input  logic     rst_act,
    input  logic     pre_act,
    output logic     q
);

    logic state;
    logic open_l;
    logic fire;

    assign open_l = (mode == MODE_LATCH) && ck_lvl && en;
    assign fire   = ck_rise && en;

    // Update stored state: system reset, then cell reset, preset, mode action.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= 1'b0;
        end else if (rst_act) begin
            state <= 1'b0;
        end else if (pre_act) begin
            state <= 1'b1;
        end else begin
            case (mode)
                MODE_LATCH:  if (open_l)      state <= d;
                MODE_TOGGLE: if (fire && d)   state <= ~state;
                default:     if (fire)        state <= d;
            endcase
        end
    end

    // Visible value: overrides first, then latch flow-through, then state.
    always_comb begin
        if (rst_act)      q = 1'b0;
        else if (pre_act) q = 1'b1;
        else if (open_l)  q = d;
        else              q = state;
    end

    AST_RESET_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        rst_act |=> (state == 1'b0)); // R9
    AST_PRESET_SETS: assert property (@(posedge clk) disable iff (!rst_n)
        (pre_act && !rst_act) |=> (state == 1'b1)); // R8
    AST_DREG_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        ((mode == MODE_DREG || mode == MODE_DALT) && !rst_act && !pre_act && !fire)
        |=> $stable(state)); // R3
    AST_TOGGLE_FLIP: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == MODE_TOGGLE && !rst_act && !pre_act && fire && d)
        |=> (state != $past(state))); // R5
    AST_LATCH_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == MODE_LATCH && !rst_act && !pre_act && !open_l)
        |=> $stable(state)); // R4

endmodule

// File: rtl/mc_macrocell.sv
// Module: one configurable logic macrocell. Polarity XOR on the product
// term, selectable storage, four selectable control lines, two outputs.
// Assumes: configuration inputs are static; cell clocks are sampled by clk.
module mc_macrocell
    import mc_pkg::*;
#(
    parameter int N_GCLK = 4,
    parameter int N_LCLK = 3,
    parameter int N_GCE  = 2,
    parameter int N_LCE  = 2,
    parameter int N_GSR  = 2,
    localparam int CK_N  = N_GCLK + N_LCLK + 2,
    localparam int CE_N  = N_GCE + N_LCE + 2,
    localparam int SR_N  = N_GSR + 2,
    localparam int CK_W  = $clog2(CK_N),
    localparam int CE_W  = $clog2(CE_N),
    localparam int SR_W  = $clog2(SR_N)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [1:0]        cfg_mode,
    input  logic              cfg_xor_inv,
    input  logic              cfg_fb_store,
    input  logic              cfg_rt_store,
    input  logic [CK_W-1:0]   cfg_ck_sel,
    input  logic              cfg_ck_inv,
    input  logic [CE_W-1:0]   cfg_ce_sel,
    input  logic              cfg_ce_inv,
    input  logic [SR_W-1:0]   cfg_rs_sel,
    input  logic              cfg_rs_inv,
    input  logic [SR_W-1:0]   cfg_ps_sel,
    input  logic              cfg_ps_inv,
    input  logic [N_GCLK-1:0] gclk,
    input  logic [N_LCLK-1:0] lclk,
    input  logic              pt_clk,
    input  logic [N_GCE-1:0]  gce,
    input  logic [N_LCE-1:0]  lce,
    input  logic              pt_ce,
    input  logic [N_GSR-1:0]  gsr,
    input  logic              pt_rst,
    input  logic              pt_pre,
    input  logic              sop,
    output logic              fb_out,
    output logic              rt_out
);

    localparam int N_OUT = 2;

    logic [CK_N-1:0] ck_src;
    logic [CE_N-1:0] ce_src;
    logic [SR_N-1:0] rs_src;
    logic [SR_N-1:0] ps_src;
    logic            ck_lvl, ck_rise, en, rst_act, pre_act;
    logic            d, q;
    logic [N_OUT-1:0] out_pick;
    logic [N_OUT-1:0] outs;
    mc_mode_e        mode;

    assign mode   = mc_mode_e'(cfg_mode);
    assign d      = sop ^ cfg_xor_inv;
    assign ck_src = {pt_clk, lclk, gclk, 1'b0};
    assign ce_src = {pt_ce, lce, gce, 1'b0};
    assign rs_src = {pt_rst, gsr, 1'b0};
    assign ps_src = {pt_pre, gsr, 1'b0};

    mc_src_sel #(.N_SRC(CK_N), .SEL_W(CK_W)) u_ck_sel (
        .src(ck_src), .sel(cfg_ck_sel), .inv(cfg_ck_inv), .sig(ck_lvl));
    mc_src_sel #(.N_SRC(CE_N), .SEL_W(CE_W)) u_ce_sel (
        .src(ce_src), .sel(cfg_ce_sel), .inv(cfg_ce_inv), .sig(en));
    mc_src_sel #(.N_SRC(SR_N), .SEL_W(SR_W)) u_rs_sel (
        .src(rs_src), .sel(cfg_rs_sel), .inv(cfg_rs_inv), .sig(rst_act));
    mc_src_sel #(.N_SRC(SR_N), .SEL_W(SR_W)) u_ps_sel (
        .src(ps_src), .sel(cfg_ps_sel), .inv(cfg_ps_inv), .sig(pre_act));

    mc_edge u_edge (
        .clk(clk), .rst_n(rst_n), .lvl(ck_lvl), .rise(ck_rise));

    mc_store u_store (
        .clk(clk), .rst_n(rst_n), .mode(mode), .d(d),
        .ck_lvl(ck_lvl), .ck_rise(ck_rise), .en(en),
        .rst_act(rst_act), .pre_act(pre_act), .q(q));

    // Each output independently picks the stored or the combinational value.
    assign out_pick = {cfg_rt_store, cfg_fb_store};
    for (genvar g = 0; g < N_OUT; g++) begin : g_out
        assign outs[g] = out_pick[g] ? q : d;
    end
    assign fb_out = outs[0];
    assign rt_out = outs[1];

    AST_COMB_ROUTE: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_rt_store |-> (rt_out == (sop ^ cfg_xor_inv))); // R1
    AST_COMB_FEEDBACK: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_fb_store |-> (fb_out == (sop ^ cfg_xor_inv))); // R2
    AST_BOTH_OVERRIDES: assert property (@(posedge clk) disable iff (!rst_n)
        (rst_act && pre_act && cfg_fb_store) |-> (fb_out == 1'b0)); // R9

endmodule

// File: tb/mc_macrocell_tb.sv
module mc_macrocell_tb;

    typedef struct {
        logic  fb;
        logic  rt;
        string tag;
    } exp_t;

    logic       clk = 1'b0;
    logic       rst_n;
    logic [1:0] cfg_mode;
    logic       cfg_xor_inv, cfg_fb_store, cfg_rt_store;
    logic [3:0] cfg_ck_sel;
    logic       cfg_ck_inv;
    logic [2:0] cfg_ce_sel;
    logic       cfg_ce_inv;
    logic [1:0] cfg_rs_sel, cfg_ps_sel;
    logic       cfg_rs_inv, cfg_ps_inv;
    logic [3:0] gclk;
    logic [2:0] lclk;
    logic       pt_clk;
    logic [1:0] gce, lce, gsr;
    logic       pt_ce, pt_rst, pt_pre, sop;
    logic       fb_out, rt_out;

    exp_t sb_q[$];
    int   n_chk  = 0;
    int   n_fail = 0;
    bit   done   = 0;

    always #2 clk = ~clk;

    mc_macrocell u_dut (
        .clk(clk), .rst_n(rst_n), .cfg_mode(cfg_mode), .cfg_xor_inv(cfg_xor_inv),
        .cfg_fb_store(cfg_fb_store), .cfg_rt_store(cfg_rt_store),
        .cfg_ck_sel(cfg_ck_sel), .cfg_ck_inv(cfg_ck_inv),
        .cfg_ce_sel(cfg_ce_sel), .cfg_ce_inv(cfg_ce_inv),
        .cfg_rs_sel(cfg_rs_sel), .cfg_rs_inv(cfg_rs_inv),
        .cfg_ps_sel(cfg_ps_sel), .cfg_ps_inv(cfg_ps_inv),
        .gclk(gclk), .lclk(lclk), .pt_clk(pt_clk), .gce(gce), .lce(lce),
        .pt_ce(pt_ce), .gsr(gsr), .pt_rst(pt_rst), .pt_pre(pt_pre),
        .sop(sop), .fb_out(fb_out), .rt_out(rt_out));

    // Driver side: record what both outputs must show in this cycle.
    task automatic expect_out(input logic fb, input logic rt, input string tag);
        exp_t e;
        e.fb = fb; e.rt = rt; e.tag = tag;
        sb_q.push_back(e);
    endtask

    task automatic step;
        @(negedge clk);
    endtask

    // Monitor: compare outputs one time unit after the driver's edge.
    initial begin
        forever begin
            @(negedge clk);
            #1;
            while (sb_q.size() > 0) begin
                exp_t e;
                e = sb_q.pop_front();
                n_chk++;
                if (fb_out !== e.fb || rt_out !== e.rt) begin
                    n_fail++;
                    $display("FAIL %s: fb_out=%b rt_out=%b expected fb=%b rt=%b",
                             e.tag, fb_out, rt_out, e.fb, e.rt);
                end
            end
        end
    end

    // Watchdog.
    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            n_fail++; n_chk++;
            $display("FAIL watchdog: run did not complete");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        rst_n = 0; cfg_mode = 2'b00; cfg_xor_inv = 0;
        cfg_fb_store = 1; cfg_rt_store = 0;
        cfg_ck_sel = 4'd1; cfg_ck_inv = 0;
        cfg_ce_sel = 3'd0; cfg_ce_inv = 1;
        cfg_rs_sel = 2'd0; cfg_rs_inv = 0;
        cfg_ps_sel = 2'd0; cfg_ps_inv = 0;
        gclk = 0; lclk = 0; pt_clk = 0; gce = 0; lce = 0; pt_ce = 0;
        gsr = 0; pt_rst = 0; pt_pre = 0; sop = 0;
        repeat (3) step;
        // Reset state and combinational path (R10, R1)
        step; rst_n = 1; sop = 1;            expect_out(0, 1, "R10 reset state");
        // D register on gclk[0]
        step; gclk[0] = 1;                   expect_out(0, 1, "R3 before capture");
        step; sop = 0;                       expect_out(1, 0, "R3 captured 1");
        step; gclk[0] = 0;                   expect_out(1, 0, "R3 falling edge holds");
        step; gclk[0] = 1;                   expect_out(1, 0, "R3 edge pending");
        step; gclk[0] = 0;                   expect_out(0, 0, "R3 captured 0");
        // Enable from gce[0]
        step; cfg_ce_sel = 3'd1; cfg_ce_inv = 0; gclk[0] = 1; sop = 1;
                                             expect_out(0, 1, "R7 edge while disabled");
        step; gclk[0] = 0;                   expect_out(0, 1, "R7 disabled edge ignored");
        step; gclk[0] = 1; gce[0] = 1;       expect_out(0, 1, "R7 enabled edge");
        step; gclk[0] = 0; gce[0] = 0; cfg_ce_sel = 3'd0; cfg_ce_inv = 1;
                                             expect_out(1, 1, "R7 enabled capture");
        // Polarity XOR
        step; cfg_xor_inv = 1;               expect_out(1, 0, "R1 inverted comb");
        step; gclk[0] = 1;                   expect_out(1, 0, "R1 inverted edge");
        step; gclk[0] = 0;                   expect_out(0, 0, "R1 inverted stored");
        // Inverted clock on lclk[1]
        step; cfg_xor_inv = 0; cfg_ck_sel = 4'd6; cfg_ck_inv = 1; lclk[1] = 1;
                                             expect_out(0, 1, "R6 select lclk1");
        step; lclk[1] = 0;                   expect_out(0, 1, "R6 falling line");
        step; lclk[1] = 1; sop = 0;          expect_out(1, 0, "R6 falling edge active");
        step;                                expect_out(1, 0, "R6 rising line ignored");
        step; gclk[0] = 1;                   expect_out(1, 0, "R6 unselected gclk");
        step; gclk[0] = 0;                   expect_out(1, 0, "R6 unselected gclk low");
        // Out-of-range clock index
        step; cfg_ck_sel = 4'd12; cfg_ck_inv = 0; gclk = 4'hF; lclk = 3'h7; pt_clk = 1;
                                             expect_out(1, 0, "R11 range high");
        step; gclk = 0; lclk = 0; pt_clk = 0; expect_out(1, 0, "R11 range low");
        step; gclk = 4'hF; lclk = 3'h7; pt_clk = 1;
                                             expect_out(1, 0, "R11 range no edge");
        // Product-term clock
        step; cfg_ck_sel = 4'd8; gclk = 0; lclk = 0; pt_clk = 0;
                                             expect_out(1, 0, "R6 pt clock idle");
        step; pt_clk = 1;                    expect_out(1, 0, "R6 pt clock edge");
        step; pt_clk = 0;                    expect_out(0, 0, "R6 pt clock captured");
        // Toggle mode
        step; cfg_mode = 2'b10; sop = 1;     expect_out(0, 1, "R5 toggle idle");
        step; pt_clk = 1;                    expect_out(0, 1, "R5 toggle edge");
        step; pt_clk = 0;                    expect_out(1, 1, "R5 toggled to 1");
        step; pt_clk = 1; sop = 0;           expect_out(1, 0, "R5 edge with d 0");
        step; pt_clk = 0; sop = 1;           expect_out(1, 1, "R5 held with d 0");
        step; pt_clk = 1;                    expect_out(1, 1, "R5 second edge");
        step; pt_clk = 0;                    expect_out(0, 1, "R5 toggled to 0");
        // Mode 11 acts as D
        step; cfg_mode = 2'b11; pt_clk = 1;  expect_out(0, 1, "R5 alt edge");
        step; pt_clk = 0; sop = 0;           expect_out(1, 0, "R5 alt captured 1");
        step; pt_clk = 1; sop = 1;           expect_out(1, 1, "R5 alt edge d 1");
        step; pt_clk = 0;                    expect_out(1, 1, "R5 alt not toggled");
        // Latch mode
        step; cfg_mode = 2'b01; sop = 0;     expect_out(1, 0, "R4 latch closed");
        step; pt_clk = 1;                    expect_out(0, 0, "R4 latch open 0");
        step; sop = 1;                       expect_out(1, 1, "R4 latch follows 1");
        step; pt_clk = 0; sop = 0;           expect_out(1, 0, "R4 latch holds");
        step;                                expect_out(1, 0, "R4 latch still holds");
        step; cfg_ce_sel = 3'd5; cfg_ce_inv = 0; pt_ce = 0; pt_clk = 1;
                                             expect_out(1, 0, "R4 enable closes latch");
        step; pt_ce = 1;                     expect_out(0, 0, "R7 enable opens latch");
        step; pt_clk = 0; pt_ce = 0; sop = 1; expect_out(0, 1, "R4 latch held 0");
        // Reset and preset
        step; cfg_mode = 2'b00; cfg_ce_sel = 3'd0; cfg_ce_inv = 1;
              cfg_rs_sel = 2'd3; cfg_ps_sel = 2'd1; gsr[0] = 1; sop = 0;
                                             expect_out(1, 0, "R8 preset immediate");
        step; gsr[0] = 0;                    expect_out(1, 0, "R8 preset stored");
        step; pt_rst = 1;                    expect_out(0, 0, "R8 reset immediate");
        step; gsr[0] = 1;                    expect_out(0, 0, "R9 both active");
        step; pt_rst = 0;                    expect_out(1, 0, "R8 preset alone");
        step; pt_rst = 1; pt_clk = 1; sop = 1; expect_out(0, 1, "R9 reset with edge");
        step; pt_rst = 0; gsr[0] = 0; pt_clk = 0; sop = 0;
                                             expect_out(0, 0, "R9 reset won over edge");
        step; cfg_rs_sel = 2'd2; cfg_rs_inv = 1; gsr = 2'b11;
                                             expect_out(1, 0, "R8 inverted reset idle");
        step; gsr = 2'b00;                   expect_out(0, 0, "R8 inverted reset active");
        step; cfg_rs_sel = 2'd0; cfg_rs_inv = 0;
                                             expect_out(0, 0, "R8 reset released");
        // Swapped output paths
        step; cfg_fb_store = 0; cfg_rt_store = 1; gsr[0] = 1;
                                             expect_out(0, 1, "R2 swapped paths");
        step; gsr[0] = 0; sop = 1;           expect_out(1, 1, "R2 fb comb rt stored");
        step; sop = 0;                       expect_out(0, 1, "R2 independent");
        // System reset mid-run
        step; rst_n = 0;                     expect_out(0, 1, "R10 before sync reset");
        step; rst_n = 1;                     expect_out(0, 0, "R10 cleared");
        step; step;
        done = 1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule